// File: doc/BRIEF.md
# Sample Playback DMA Address Engine

This block walks a sample buffer held in memory and turns it into a paced stream of left and right audio samples. Software programs a 24-bit start address and a 24-bit stop address, one byte at a time, chooses a sample format and one of four playback rates, and then sets the run bit. The engine fetches 16-bit words through a request/response memory port. It keeps a few words in a small prefetch buffer. At every sample period it presents one left/right pair with a one-cycle strobe.

When the fetch pointer reaches the stop address, the engine raises a one-cycle end-of-buffer pulse. In one-shot mode it clears its run bit. The words already fetched still play out, and then the strobes stop. In looping mode it reloads the pointer from the start address as currently programmed. Playback continues with no gap in the sample stream. Software can therefore program the next buffer while the present one plays.

The memory request side is valid/ready. The engine holds `mem_req_valid` and `mem_req_addr` steady until the cycle in which `mem_req_ready` is high. The engine has at most one request outstanding. The response is a one-cycle `mem_rsp_valid` with data, at any latency. The engine accepts it unconditionally, so the response side has no ready. The sample side has no back-pressure, because the output rate is set by the rate timer.

Top module: `adma_engine`

## Requirements
- R1: Register offsets on `reg_addr` are: 0 control, 1 format, 2/3/4 start address high/middle/low, 5/6/7 stop address high/middle/low, and 8/9/10 fetch pointer high/middle/low (read-only). Reads at any other offset return 0. The format register keeps only bits 7, 6, 1 and 0, and reads the other bits as 0. After reset every register reads 0 and no strobe, request or end pulse is active.
- R2: Control bit 0 is run and bit 1 is loop. Writing a control value with bit 0 clear stops the engine at once. After a stop, no new memory request is issued and buffered words are discarded. From the second cycle after the write, no sample strobe appears.
- R3: When run goes from 0 to 1, the start and stop addresses are captured with bit 0 forced to 0. Words are then requested at start, start+2, start+4 and so on. A request stays valid with a stable address until it is accepted, and only one request is outstanding at a time.
- R4: When the pointer equals the captured stop address and no request is in flight, `buf_end` pulses for one cycle. In one-shot mode the run bit then reads 0. A buffer whose start equals its stop produces one pulse and no request.
- R5: In loop mode, the programmed start and stop addresses are captured again at each wrap. Writes made during playback take effect only at the next wrap or the next start.
- R6: Sample slots occur every PRESCALE × 2^(3−code) clock cycles, where code is format bits [1:0]. A strobe is issued in a slot only if a full frame is buffered.
- R7: In 8-bit stereo (format bit 7 = 0, bit 6 = 0), each word gives left = its high byte and right = its low byte. Each 8-bit sample appears in bits [15:8] of the output, with bits [7:0] zero.
- R8: In 8-bit mono (bit 7 = 1, bit 6 = 0), each word gives two samples, the high byte first and then the low byte. Each sample drives both outputs.
- R9: In 16-bit mono (bit 7 = 1, bit 6 = 1), each word drives both outputs. In 16-bit stereo (bit 7 = 0, bit 6 = 1), two consecutive words form one frame, the first on the left.
- R10: With 16-bit samples and rate code 0, the outputs are zero. Words are still consumed at that rate.
- R11: The fetch pointer readback is high<<16 + middle<<8 + low, and it names the next word to fetch. After a one-shot buffer completes, it reads the stop address.
- R12: The engine never holds more than FIFO_DEPTH fetched but unplayed words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from `reg_addr`) |
| mem_req_valid | output | 1 | Word read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 24 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid (one cycle) |
| mem_rsp_data | input | 16 | Read data word |
| smp_valid | output | 1 | One-cycle sample strobe |
| smp_left | output | 16 | Left sample |
| smp_right | output | 16 | Right sample |
| buf_end | output | 1 | End-of-buffer pulse |

## Verification
The embedded properties check the following on every cycle:
- the request hold rule;
- that no request is issued at the stop address;
- that the prefetch buffer neither overflows nor underflows;
- the minimum spacing between strobes;
- the zero outputs in muted mode;
- that a one-shot end pulse clears the run bit.

Only the bench scenarios can show the rest, by comparing every strobe against a behavioural model:
- the order of samples in each format;
- the exact slot period at each rate code;
- the switch to a newly programmed buffer at a looping wrap;
- that nothing emerges after a stop.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int ADDR_W = 24;
  localparam int WORD_W = 16;

  localparam logic [3:0] RA_CTRL   = 4'd0;
  localparam logic [3:0] RA_FMT    = 4'd1;
  localparam logic [3:0] RA_BASE_H = 4'd2;
  localparam logic [3:0] RA_BASE_M = 4'd3;
  localparam logic [3:0] RA_BASE_L = 4'd4;
  localparam logic [3:0] RA_STOP_H = 4'd5;
  localparam logic [3:0] RA_STOP_M = 4'd6;
  localparam logic [3:0] RA_STOP_L = 4'd7;
  localparam logic [3:0] RA_PTR_H  = 4'd8;
  localparam logic [3:0] RA_PTR_M  = 4'd9;
  localparam logic [3:0] RA_PTR_L  = 4'd10;

  typedef struct packed {
    logic       mono;
    logic       wide;
    logic [1:0] rate;
  } fmt_t;

  function automatic logic [ADDR_W-1:0] word_align(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:1], 1'b0};
  endfunction
endpackage

// File: rtl/adma_rate_timer.sv
module adma_rate_timer #(
  parameter int PRESCALE = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] rate,
  output logic       slot
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;
  logic [2:0]    unit_q;
  logic [2:0]    unit_last;

  assign unit_last = 3'd7 >> rate;
  assign slot = run && (pre_q == P_LAST) && (unit_q >= unit_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pre_q  <= '0;
      unit_q <= '0;
    end else if (pre_q == P_LAST) begin
      pre_q  <= '0;
      unit_q <= (unit_q >= unit_last) ? 3'd0 : unit_q + 3'd1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/adma_word_fifo.sv
module adma_word_fifo #(
  parameter int WW    = 16,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [WW-1:0] din,
  input  logic [1:0]    pop_n,
  output logic [WW-1:0] head,
  output logic [WW-1:0] second,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [WW-1:0] mem_q [DEPTH];
  logic [AW-1:0] rd_q, wr_q;

  assign head   = mem_q[rd_q];
  assign second = mem_q[rd_q + AW'(1)];

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      wr_q  <= wr_q + AW'(push);
      rd_q  <= rd_q + AW'(pop_n);
      count <= count + CW'(push) - CW'(pop_n);
    end
  end

  p_fifo_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> (count < CW'(DEPTH)));
  p_fifo_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (CW'(pop_n) <= count));
endmodule

// File: rtl/adma_fetch.sv
module adma_fetch
  import adma_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              loop_en,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [ADDR_W-1:0] stop_in,
  input  logic [CW-1:0]     fcount,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              push,
  output logic [WORD_W-1:0] push_data,
  output logic              at_end,
  output logic [ADDR_W-1:0] ptr
);
  logic [ADDR_W-1:0] stop_w;
  logic busy_q, drop_q;
  logic room;

  assign room         = fcount < CW'(DEPTH);
  assign mem_req_addr = ptr;
  assign at_end       = active && !mem_req_valid && !busy_q && (ptr == stop_w);
  assign push         = mem_rsp_valid && busy_q && !drop_q && active;
  assign push_data    = mem_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_w        <= '0;
      ptr           <= '0;
      mem_req_valid <= 1'b0;
      busy_q        <= 1'b0;
      drop_q        <= 1'b0;
    end else begin
      if (mem_rsp_valid && busy_q) begin
        busy_q <= 1'b0;
        drop_q <= 1'b0;
      end
      if (start) begin
        stop_w        <= word_align(stop_in);
        ptr           <= word_align(base_in);
        mem_req_valid <= 1'b0;
      end else if (!active) begin
        mem_req_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
          busy_q <= 1'b1;
          drop_q <= 1'b1;
        end else if (busy_q && !mem_rsp_valid) begin
          drop_q <= 1'b1;
        end
      end else if (mem_req_valid) begin
        if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          busy_q        <= 1'b1;
          ptr           <= ptr + ADDR_W'(2);
        end
      end else if (at_end) begin
        if (loop_en) begin
          stop_w <= word_align(stop_in);
          ptr    <= word_align(base_in);
        end
      end else if (!busy_q && room) begin
        mem_req_valid <= 1'b1;
      end
    end
  end

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && active) |=>
      (!active || (mem_req_valid && $stable(mem_req_addr))));
  p_req_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && active) |-> (mem_req_addr != stop_w));
  p_single_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !mem_req_valid);
endmodule

// File: rtl/adma_engine.sv
module adma_engine
  import adma_pkg::*;
#(
  parameter int PRESCALE   = 256,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  output logic              smp_valid,
  output logic [WORD_W-1:0] smp_left,
  output logic [WORD_W-1:0] smp_right,
  output logic              buf_end
);
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam int GW = $clog2(PRESCALE + 1);

  logic              run_q, loop_q;
  fmt_t              fmt_q;
  logic [ADDR_W-1:0] base_q, stop_q, ptr;
  logic              ctrl_wr, start, stop, at_end;
  logic              push, slot, fire, half_q;
  logic [WORD_W-1:0] push_data, w0, w1;
  logic [CW-1:0]     fcount;
  logic [1:0]        pop_n;
  logic              stereo16, mono8, mute, frame_ok;
  logic [WORD_W-1:0] nxt_l, nxt_r;
  logic [7:0]        byte_pick;

  assign ctrl_wr = reg_we && (reg_addr == RA_CTRL);
  assign start   = ctrl_wr && reg_wdata[0] && !run_q;
  assign stop    = ctrl_wr && !reg_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      loop_q <= 1'b0;
      fmt_q  <= '0;
      base_q <= '0;
      stop_q <= '0;
    end else begin
      if (reg_we) begin
        case (reg_addr)
          RA_FMT:    fmt_q <= '{mono: reg_wdata[7], wide: reg_wdata[6], rate: reg_wdata[1:0]};
          RA_BASE_H: base_q[23:16] <= reg_wdata;
          RA_BASE_M: base_q[15:8]  <= reg_wdata;
          RA_BASE_L: base_q[7:0]   <= reg_wdata;
          RA_STOP_H: stop_q[23:16] <= reg_wdata;
          RA_STOP_M: stop_q[15:8]  <= reg_wdata;
          RA_STOP_L: stop_q[7:0]   <= reg_wdata;
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        run_q  <= reg_wdata[0];
        loop_q <= reg_wdata[1];
      end else if (at_end && !loop_q) begin
        run_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = {6'b0, loop_q, run_q};
      RA_FMT:    reg_rdata = {fmt_q.mono, fmt_q.wide, 4'b0, fmt_q.rate};
      RA_BASE_H: reg_rdata = base_q[23:16];
      RA_BASE_M: reg_rdata = base_q[15:8];
      RA_BASE_L: reg_rdata = base_q[7:0];
      RA_STOP_H: reg_rdata = stop_q[23:16];
      RA_STOP_M: reg_rdata = stop_q[15:8];
      RA_STOP_L: reg_rdata = stop_q[7:0];
      RA_PTR_H:  reg_rdata = ptr[23:16];
      RA_PTR_M:  reg_rdata = ptr[15:8];
      RA_PTR_L:  reg_rdata = ptr[7:0];
      default:   reg_rdata = 8'h00;
    endcase
  end

  adma_fetch #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_fetch (
    .clk, .rst_n, .start, .active(run_q), .loop_en(loop_q),
    .base_in(base_q), .stop_in(stop_q), .fcount,
    .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_data,
    .push, .push_data, .at_end, .ptr
  );

  adma_word_fifo #(.WW(WORD_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_fifo (
    .clk, .rst_n, .flush(start || stop), .push, .din(push_data),
    .pop_n, .head(w0), .second(w1), .count(fcount)
  );

  adma_rate_timer #(.PRESCALE(PRESCALE)) u_timer (
    .clk, .rst_n, .run(run_q || (fcount != '0)), .rate(fmt_q.rate), .slot
  );

  assign stereo16  = fmt_q.wide && !fmt_q.mono;
  assign mono8     = !fmt_q.wide && fmt_q.mono;
  assign mute      = fmt_q.wide && (fmt_q.rate == 2'd0);
  assign frame_ok  = stereo16 ? (fcount >= CW'(2)) : (fcount != '0);
  assign fire      = slot && frame_ok && !stop;
  assign byte_pick = half_q ? w0[7:0] : w0[15:8];

  always_comb begin
    if (!fire)                 pop_n = 2'd0;
    else if (stereo16)         pop_n = 2'd2;
    else if (mono8 && !half_q) pop_n = 2'd0;
    else                       pop_n = 2'd1;
  end

  always_comb begin
    nxt_l = '0;
    nxt_r = '0;
    if (!mute) begin
      case ({fmt_q.wide, fmt_q.mono})
        2'b00: begin nxt_l = {w0[15:8], 8'h00}; nxt_r = {w0[7:0], 8'h00}; end
        2'b01: begin nxt_l = {byte_pick, 8'h00}; nxt_r = {byte_pick, 8'h00}; end
        2'b10: begin nxt_l = w0; nxt_r = w1; end
        default: begin nxt_l = w0; nxt_r = w0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_left  <= '0;
      smp_right <= '0;
      buf_end   <= 1'b0;
      half_q    <= 1'b0;
    end else begin
      smp_valid <= fire;
      buf_end   <= at_end;
      if (fire) begin
        smp_left  <= nxt_l;
        smp_right <= nxt_r;
      end
      if (start || stop)        half_q <= 1'b0;
      else if (fire && mono8)   half_q <= ~half_q;
    end
  end

  logic [GW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (smp_valid) begin
      gap_q  <= GW'(1);
      seen_q <= 1'b1;
    end else if (gap_q < GW'(PRESCALE)) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  p_strobe_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && seen_q) |-> (gap_q >= GW'(PRESCALE)));
  p_mute_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && $past(fmt_q.wide && fmt_q.rate == 2'd0)) |->
      (smp_left == '0 && smp_right == '0));
  p_oneshot_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_end && !$past(loop_q) && !$past(ctrl_wr)) |-> !run_q);
  p_idle_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> $past(run_q || fcount != '0));
endmodule

// File: tb/tb_adma_engine.sv
module tb_adma_engine;
  localparam int PS = 16;
  localparam int FD = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [23:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        smp_valid, buf_end;
  logic [15:0] smp_left, smp_right;

  always #2.5 clk = ~clk;

  adma_engine #(.PRESCALE(PS), .FIFO_DEPTH(FD)) dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .smp_valid, .smp_left, .smp_right, .buf_end
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] wd(input logic [23:0] a);
    logic [7:0] i;
    i = a[8:1];
    return {i ^ 8'hA5, i + 8'h3C};
  endfunction

  // reference model state
  logic [31:0] expq[$];
  logic [23:0] addrq[$];
  logic [15:0] pend;
  bit          have_pend;
  string       cur_req = "R7";
  int          period = PS;
  bit          mon_on = 0, depth_on = 0, post_stop = 0;
  int          cyc = 0, last_t = -1, nstrobe = 0, eob_n = 0, post_cnt = 0;
  int          halves_in = 0, halves_used = 0, used_per = 2, depth_err = 0;
  int          wait_cnt = 0;
  logic [23:0] rsp_addr;
  bit          hold_pend = 0;
  logic [23:0] hold_addr;

  task automatic add_buf(input logic [23:0] b, input logic [23:0] e, input logic [7:0] f);
    for (int a = int'(b); a < int'(e); a += 2) begin
      logic [15:0] w;
      w = wd(24'(a));
      addrq.push_back(24'(a));
      if (f[6] && f[1:0] == 2'd0) w = 16'h0;
      case ({f[6], f[7]})
        2'b00: expq.push_back({w[15:8], 8'h00, w[7:0], 8'h00});
        2'b01: begin
          expq.push_back({w[15:8], 8'h00, w[15:8], 8'h00});
          expq.push_back({w[7:0], 8'h00, w[7:0], 8'h00});
        end
        2'b10: if (!have_pend) begin pend = w; have_pend = 1; end
               else begin expq.push_back({pend, w}); have_pend = 0; end
        default: expq.push_back({w, w});
      endcase
    end
  endtask

  // memory model and per-cycle comparison
  always @(negedge clk) begin
    cyc++;
    if (mon_on && smp_valid) begin
      nstrobe++;
      if (expq.size() == 0) chk(0, "R2", "unexpected strobe", {smp_left, smp_right}, 0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk({smp_left, smp_right} == e, cur_req, "sample pair", {smp_left, smp_right}, e);
      end
      if (last_t >= 0) chk(cyc - last_t == period, "R6", "strobe spacing", cyc - last_t, period);
      last_t = cyc;
      halves_used += used_per;
    end
    if (mon_on && buf_end) eob_n++;
    if (post_stop && smp_valid) post_cnt++;
    mem_rsp_valid = 1'b0;
    if (wait_cnt > 0) begin
      wait_cnt--;
      if (wait_cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = wd(rsp_addr);
        halves_in += 2;
      end
    end
    if (depth_on && (halves_in - halves_used > 2 * FD)) depth_err++;
    if (hold_pend && mon_on)
      chk(mem_req_valid && mem_req_addr == hold_addr, "R3", "request hold", mem_req_addr, hold_addr);
    hold_pend = 0;
    mem_req_ready = (cyc % 3) != 1;
    if (mem_req_valid && mem_req_ready && wait_cnt == 0) begin
      rsp_addr = mem_req_addr;
      wait_cnt = 2;
      if (post_stop) post_cnt++;
      if (mon_on && addrq.size() != 0) begin
        logic [23:0] ea;
        ea = addrq.pop_front();
        chk(mem_req_addr == ea, "R3", "request address", mem_req_addr, ea);
      end else if (mon_on) chk(0, "R4", "request past buffer", mem_req_addr, 0);
    end else if (mem_req_valid && !mem_req_ready) begin
      hold_pend = 1;
      hold_addr = mem_req_addr;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_buf(input logic [23:0] b, input logic [23:0] e);
    wr(4'd2, b[23:16]); wr(4'd3, b[15:8]); wr(4'd4, b[7:0]);
    wr(4'd5, e[23:16]); wr(4'd6, e[15:8]); wr(4'd7, e[7:0]);
  endtask

  task automatic rd_ptr(output logic [23:0] p);
    logic [7:0] h, m, l;
    rd(4'd8, h); rd(4'd9, m); rd(4'd10, l);
    p = (24'(h) << 16) + (24'(m) << 8) + 24'(l);
  endtask

  task automatic begin_run(input logic [7:0] f, input string req);
    expq.delete(); addrq.delete(); have_pend = 0;
    cur_req = req; period = PS * (8 >> f[1:0]);
    used_per = (f[6] && !f[7]) ? 4 : (!f[6] && f[7]) ? 1 : 2;
    last_t = -1; nstrobe = 0; eob_n = 0;
    halves_in = 0; halves_used = 0; depth_err = 0;
  endtask

  task automatic oneshot(input logic [23:0] b, input logic [23:0] e,
                         input logic [7:0] f, input string req);
    logic [7:0] c;
    logic [23:0] p;
    begin_run(f, req);
    add_buf(b, e, f);
    set_buf(b, e);
    wr(4'd1, f);
    mon_on = 1; depth_on = 1;
    wr(4'd0, 8'h01);
    for (int i = 0; i < 20000; i++) begin
      rd(4'd0, c);
      if (c[0] == 1'b0 && expq.size() == 0) break;
    end
    repeat (3 * period) @(negedge clk);
    mon_on = 0; depth_on = 0;
    chk(expq.size() == 0, req, "samples left unplayed", expq.size(), 0);
    chk(addrq.size() == 0, "R3", "requests not issued", addrq.size(), 0);
    chk(eob_n == 1, "R4", "end pulses", eob_n, 1);
    chk(c == 8'h00, "R4", "run bit after end", c, 0);
    chk(depth_err == 0, "R12", "prefetch beyond depth", depth_err, 0);
    rd_ptr(p);
    chk(p == e, "R11", "pointer after end", p, e);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    report();
  end

  initial begin
    logic [7:0] d;
    logic [23:0] p;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      chk(d == 8'h00, "R1", "register after reset", d, 0);
    end
    chk(!smp_valid && !mem_req_valid && !buf_end, "R1", "outputs after reset",
        {smp_valid, mem_req_valid, buf_end}, 0);
    // R1: readback and format masking
    set_buf(24'h123456, 24'h89ABCD);
    rd(4'd2, d); chk(d == 8'h12, "R1", "start high", d, 8'h12);
    rd(4'd4, d); chk(d == 8'h56, "R1", "start low", d, 8'h56);
    rd(4'd6, d); chk(d == 8'hAB, "R1", "stop middle", d, 8'hAB);
    wr(4'd1, 8'hFF);
    rd(4'd1, d); chk(d == 8'hC3, "R1", "format mask", d, 8'hC3);
    rd(4'd13, d); chk(d == 8'h00, "R1", "unused offset", d, 0);

    oneshot(24'h012340, 24'h01234C, 8'h03, "R7");   // 8-bit stereo, code 3
    oneshot(24'h020100, 24'h020108, 8'h82, "R8");   // 8-bit mono, code 2
    oneshot(24'h030200, 24'h030206, 8'hC1, "R9");   // 16-bit mono, code 1
    oneshot(24'h040300, 24'h040308, 8'h43, "R9");   // 16-bit stereo, code 3
    oneshot(24'h050400, 24'h050408, 8'h40, "R10");  // 16-bit, code 0: muted

    // R5 and R2: looping with a reprogrammed buffer, then stop
    begin_run(8'h03, "R5");
    add_buf(24'h001000, 24'h001010, 8'h03);
    for (int k = 0; k < 8; k++) add_buf(24'h002000, 24'h002008, 8'h03);
    set_buf(24'h001000, 24'h001010);
    wr(4'd1, 8'h03);
    mon_on = 1;
    wr(4'd0, 8'h03);
    set_buf(24'h002000, 24'h002008);
    for (int i = 0; i < 5000 && nstrobe < 20; i++) @(negedge clk);
    chk(nstrobe >= 20, "R5", "looping strobes", nstrobe, 20);
    chk(eob_n >= 3, "R4", "end pulses while looping", eob_n, 3);
    wr(4'd0, 8'h00);
    mon_on = 0;
    repeat (2) @(negedge clk);
    post_stop = 1; post_cnt = 0;
    repeat (200) @(negedge clk);
    post_stop = 0;
    chk(post_cnt == 0, "R2", "activity after stop", post_cnt, 0);
    rd(4'd0, d); chk(d == 8'h00, "R2", "control after stop", d, 0);

    // R4: empty buffer
    begin_run(8'h03, "R4");
    set_buf(24'h003000, 24'h003000);
    mon_on = 1; post_stop = 1; post_cnt = 0;
    wr(4'd0, 8'h01);
    repeat (100) @(negedge clk);
    mon_on = 0; post_stop = 0;
    chk(eob_n == 1, "R4", "empty buffer end pulse", eob_n, 1);
    chk(post_cnt == 0, "R4", "empty buffer activity", post_cnt, 0);
    rd(4'd0, d); chk(d == 8'h00, "R4", "empty buffer run bit", d, 0);
    rd_ptr(p); chk(p == 24'h003000, "R11", "empty buffer pointer", p, 24'h003000);
    report();
  end
endmodule